// File: doc/BRIEF.md
# TLB Shootdown Coordinator

This block runs the hardware side of a translation shootdown. When one core changes the access rights of a page, it hands the coordinator the virtual page number, its own core index and a conservative mask of cores that might cache that translation. The mask may name cores that hold no copy. The coordinator locks the page-table entry first. It then sends a one-cycle invalidate request to every remote core in the mask. In the same cycle it pulses the invalidate on the initiator's own TLB port. It then waits until every remote target has acknowledged. Only then does it drop the lock and pulse completion.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the coordinator is idle. A requester that is refused must keep its request valid, and it may withdraw the request before it is taken. Acknowledgements are plain per-core pulses. The completion latency of the last sequence stays readable on `latency` until the next request is taken.

Top module: `tlb_shootdown_coord`

## Requirements
- R1: After reset, `req_ready`=1 and `busy`, `pte_lock`, `done`, `ack_err`, `inv_req`, `local_inv` and `latency` are all 0.
- R2: A request is taken only on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` is 0 from the cycle after acceptance until the coordinator is idle again. A request held valid during that time has no effect.
- R3: `pte_lock` rises in the first cycle after acceptance, which is one cycle before any invalidate is issued. It stays high until the completion cycle and is low in that cycle.
- R4: In the second cycle after acceptance, `inv_req` equals the request mask with the initiator's bit cleared, for exactly one cycle. In that cycle `inv_vpn` carries the request's page number. In every other cycle `inv_req` is zero.
- R5: `local_inv` pulses in the same cycle as the remote requests, with `local_core` equal to the initiator's index. This happens even when no remote core is targeted.
- R6: `done` does not rise before each remote target has acknowledged. It rises in the cycle after the last needed acknowledgement. An acknowledgement given in the issue cycle itself counts.
- R7: The initiator's own mask bit neither produces a remote request nor requires an acknowledgement.
- R8: An acknowledgement from a core that is not pending raises `ack_err`, which stays high until reset. This covers a core outside the mask, the initiator itself, a repeated acknowledgement, and any acknowledgement outside the issue or wait cycles. Such an acknowledgement does not change when `done` rises.
- R9: `done` is high for exactly one cycle. `busy` is high from the first cycle after acceptance through the done cycle. `req_ready` returns in the cycle after `done`.
- R10: In the done cycle, `latency` equals the number of clock edges from the accepting edge to the edge that raised `done`. It keeps that value until the next acceptance.
- R11: A mask with no remote core completes with latency 2 and issues no remote request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Shootdown request valid |
| req_ready | output | 1 | Coordinator idle and able to take a request |
| req_core | input | ID_W | Index of the initiating core |
| req_vpn | input | VPN_W | Virtual page number to invalidate |
| req_mask | input | NCORES | Cores that may hold the translation |
| pte_lock | output | 1 | Page-table entry lock held |
| inv_req | output | NCORES | One-cycle invalidate request per remote core |
| inv_vpn | output | VPN_W | Page number of the sequence in progress |
| local_inv | output | 1 | One-cycle invalidate for the initiator's TLB |
| local_core | output | ID_W | Initiator index of the sequence in progress |
| ack | input | NCORES | Per-core invalidation acknowledgement pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| latency | output | LAT_W | Cycles from acceptance to completion |
| ack_err | output | 1 | Sticky flag for an unexpected acknowledgement |

## Verification
The sequence is tried with several mask shapes: all cores, a mask that leaves out the initiator, a mask that includes the initiator's bit, a mask holding only the initiator, and a sparse mask. Together these show whether the initiator's bit is filtered out and whether the local-only case skips waiting. The acknowledgement timing also varies. In some runs every target acknowledges inside the issue cycle, and in others acknowledgements arrive late and staggered. This shows whether completion follows the last acknowledgement rather than the first, and checks that the latency value matches. Further directed runs cover three more cases. One holds a second request valid while the coordinator is busy. One sends repeated, self and idle-time acknowledgements and checks that the error flag is raised without moving the completion cycle. One resets the block to confirm that the error flag clears.

// File: rtl/tlbsd_pkg.sv
package tlbsd_pkg;
  typedef enum logic [2:0] {
    SD_IDLE  = 3'd0,
    SD_LOCK  = 3'd1,
    SD_ISSUE = 3'd2,
    SD_WAIT  = 3'd3,
    SD_FIN   = 3'd4
  } sd_state_e;
endpackage

// File: rtl/tlbsd_fsm.sv
module tlbsd_fsm
  import tlbsd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      drained,
  output sd_state_e state,
  output logic      accept
);
  sd_state_e nxt;

  assign accept = (state == SD_IDLE) && req_valid;

  always_comb begin
    nxt = state;
    unique case (state)
      SD_IDLE:  if (accept) nxt = SD_LOCK;
      SD_LOCK:  nxt = SD_ISSUE;
      SD_ISSUE: nxt = drained ? SD_FIN : SD_WAIT;
      SD_WAIT:  nxt = drained ? SD_FIN : SD_WAIT;
      SD_FIN:   nxt = SD_IDLE;
      default:  nxt = SD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SD_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tlbsd_ack_tracker.sv
module tlbsd_ack_tracker #(
  parameter int NCORES = 4,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCORES-1:0] load_mask,
  input  logic [ID_W-1:0]   load_core,
  input  logic              window,
  input  logic [NCORES-1:0] ack,
  output logic [NCORES-1:0] pending,
  output logic              drained,
  output logic              err
);
  logic [NCORES-1:0] remote;
  logic [NCORES-1:0] open_set;
  logic [NCORES-1:0] taken;
  logic [NCORES-1:0] stray;
  logic [NCORES-1:0] pending_after;

  for (genvar i = 0; i < NCORES; i++) begin : g_remote
    assign remote[i] = load_mask[i] && (load_core != ID_W'(i));
  end

  assign open_set      = window ? pending : '0;
  assign taken         = ack & open_set;
  assign stray         = ack & ~open_set;
  assign pending_after = pending & ~taken;
  assign drained       = (pending_after == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      err     <= 1'b0;
    end else begin
      pending <= load ? remote : pending_after;
      err     <= err | (|stray);
    end
  end
endmodule

// File: rtl/tlbsd_latency.sv
module tlbsd_latency #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count,
  output logic [LAT_W-1:0] value
);
  localparam logic [LAT_W-1:0] LAT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          value <= '0;
    else if (clear)                      value <= '0;
    else if (count && value != LAT_MAX)  value <= value + 1'b1;
  end
endmodule

// File: rtl/tlb_shootdown_coord.sv
module tlb_shootdown_coord
  import tlbsd_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int VPN_W  = 20,
  parameter int LAT_W  = 16,
  parameter int ID_W   = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_core,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [NCORES-1:0] req_mask,
  output logic              pte_lock,
  output logic [NCORES-1:0] inv_req,
  output logic [VPN_W-1:0]  inv_vpn,
  output logic              local_inv,
  output logic [ID_W-1:0]   local_core,
  input  logic [NCORES-1:0] ack,
  output logic              busy,
  output logic              done,
  output logic [LAT_W-1:0]  latency,
  output logic              ack_err
);
  sd_state_e         state;
  logic              accept;
  logic              drained;
  logic              window;
  logic [NCORES-1:0] pending;

  tlbsd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .drained   (drained),
    .state     (state),
    .accept    (accept)
  );

  assign window = (state == SD_ISSUE) || (state == SD_WAIT);

  tlbsd_ack_tracker #(.NCORES(NCORES), .ID_W(ID_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_mask (req_mask),
    .load_core (req_core),
    .window    (window),
    .ack       (ack),
    .pending   (pending),
    .drained   (drained),
    .err       (ack_err)
  );

  tlbsd_latency #(.LAT_W(LAT_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .count (state == SD_LOCK || window),
    .value (latency)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_vpn    <= '0;
      local_core <= '0;
    end else if (accept) begin
      inv_vpn    <= req_vpn;
      local_core <= req_core;
    end
  end

  assign req_ready = (state == SD_IDLE);
  assign busy      = (state != SD_IDLE);
  assign pte_lock  = (state == SD_LOCK) || window;
  assign inv_req   = (state == SD_ISSUE) ? pending : '0;
  assign local_inv = (state == SD_ISSUE);
  assign done      = (state == SD_FIN);
endmodule

// File: rtl/tlb_shootdown_coord_chk.sv
module tlb_shootdown_coord_chk #(
  parameter int NCORES = 4,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              pte_lock,
  input logic [NCORES-1:0] inv_req,
  input logic              local_inv,
  input logic [ID_W-1:0]   local_core,
  input logic              done,
  input logic              ack_err
);
  // R3
  lock_before_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_req || local_inv) |-> (pte_lock && $past(pte_lock)));

  // R3
  unlock_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pte_lock && $past(pte_lock)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R4
  inv_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_req) |=> (inv_req == '0));

  // R7
  no_self_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_inv |-> !inv_req[local_core]);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
endmodule

bind tlb_shootdown_coord tlb_shootdown_coord_chk #(.NCORES(NCORES), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .busy       (busy),
  .pte_lock   (pte_lock),
  .inv_req    (inv_req),
  .local_inv  (local_inv),
  .local_core (local_core),
  .done       (done),
  .ack_err    (ack_err)
);

// File: tb/tlb_shootdown_coord_test.sv
`timescale 1ns/1ps
module tlb_shootdown_coord_test;
  localparam int N  = 4;
  localparam int VW = 20;
  localparam int LW = 16;
  localparam int IW = 2;
  localparam int NV = 5;

  localparam int          V_CORE [NV] = '{0, 1, 2, 3, 0};
  localparam int          V_VPN  [NV] = '{'h12345, 'h0abcd, 'h7f00f, 'h00001, 'hfffff};
  localparam logic [3:0]  V_MASK [NV] = '{4'b1111, 4'b0101, 4'b1100, 4'b1000, 4'b1110};
  localparam int          V_DLY  [NV] = '{0, 2, 1, 0, 3};
  localparam int          V_STAG [NV] = '{0, 1, 0, 0, 2};

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic          req_ready;
  logic [IW-1:0] req_core = '0;
  logic [VW-1:0] req_vpn = '0;
  logic [N-1:0]  req_mask = '0;
  logic          pte_lock;
  logic [N-1:0]  inv_req;
  logic [VW-1:0] inv_vpn;
  logic          local_inv;
  logic [IW-1:0] local_core;
  logic [N-1:0]  ack = '0;
  logic          busy;
  logic          done;
  logic [LW-1:0] latency;
  logic          ack_err;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  tlb_shootdown_coord #(.NCORES(N), .VPN_W(VW), .LAT_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_vpn(req_vpn), .req_mask(req_mask),
    .pte_lock(pte_lock), .inv_req(inv_req), .inv_vpn(inv_vpn),
    .local_inv(local_inv), .local_core(local_core), .ack(ack),
    .busy(busy), .done(done), .latency(latency), .ack_err(ack_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    ack = '0;
    req_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_shoot(input int core, input int vpn, input logic [3:0] mask,
                           input int dly, input int stag, input logic [3:0] xmask,
                           input int xc, input bit exp_err);
    logic [3:0] remote;
    int         k;
    bit         fin;
    remote = mask;
    remote[core] = 1'b0;
    k = 2;
    for (int i = 0; i < N; i++)
      if (remote[i] && (2 + dly + i*stag) > k) k = 2 + dly + i*stag;
    @(negedge clk);
    req_valid = 1;
    req_core  = IW'(core);
    req_vpn   = VW'(vpn);
    req_mask  = mask;
    chk(req_ready == 1'b1, "R2 ready before accept", int'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(pte_lock && inv_req == '0 && !local_inv, "R3 lock before invalidate",
        int'(pte_lock), 1);
    chk(busy && !req_ready, "R9 busy after accept", int'(busy), 1);
    fin = 0;
    for (int c = 1; c < 400 && !fin; c++) begin
      @(negedge clk);
      if (c == 1) begin
        chk(inv_req == remote, "R4 R7 remote fan-out", int'(inv_req), int'(remote));
        chk(inv_vpn == VW'(vpn), "R4 page number", int'(inv_vpn), vpn);
        chk(local_inv && local_core == IW'(core), "R5 local invalidate",
            int'(local_core), core);
      end else begin
        chk(inv_req == '0 && !local_inv, "R4 single issue cycle", int'(inv_req), 0);
      end
      if (done) begin
        fin = 1;
        chk(c == k, "R6 done after last ack", c, k);
        chk(int'(latency) == k, "R10 latency", int'(latency), k);
        chk(!pte_lock && busy, "R3 unlock at done", int'(pte_lock), 0);
        ack = '0;
      end else begin
        logic [3:0] a;
        chk(pte_lock, "R3 lock held", int'(pte_lock), 1);
        a = '0;
        for (int i = 0; i < N; i++)
          if (remote[i] && c == 1 + dly + i*stag) a[i] = 1'b1;
        if (c == xc) a = a | xmask;
        ack = a;
      end
    end
    if (!fin) chk(1'b0, "R6 done never seen", 0, k);
    @(negedge clk);
    chk(!done && !busy && req_ready, "R9 single done pulse and ready back",
        int'(done), 0);
    chk(int'(latency) == k, "R10 latency held", int'(latency), k);
    chk(ack_err == exp_err, "R8 error flag", int'(ack_err), int'(exp_err));
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(req_ready && !busy && !pte_lock && !done, "R1 reset control", int'(busy), 0);
    chk(!ack_err && latency == '0, "R1 reset status", int'(latency), 0);
    chk(inv_req == '0 && !local_inv, "R1 reset invalidates", int'(inv_req), 0);

    // Table walk: R4 R5 R6 R7 R10 R11 (vector 3 is local-only, R11)
    for (int v = 0; v < NV; v++)
      run_shoot(V_CORE[v], V_VPN[v], V_MASK[v], V_DLY[v], V_STAG[v], 4'b0000, 0, 1'b0);

    // R2: request held while busy is refused and leaves no trace
    @(negedge clk);
    req_valid = 1; req_core = 2'd0; req_vpn = VW'('h11111); req_mask = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    req_vpn = VW'('h22222); req_mask = 4'b1111; req_core = 2'd3;
    chk(!req_ready, "R2 refused while busy", int'(req_ready), 0);
    @(negedge clk);
    chk(inv_vpn == VW'('h11111) && inv_req == 4'b0010, "R2 first request kept",
        int'(inv_vpn), 'h11111);
    ack = 4'b0010;
    @(negedge clk);
    ack = '0;
    chk(done, "R2 first completes", int'(done), 1);
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk(!pte_lock && !busy && inv_vpn == VW'('h11111), "R2 held request ignored",
        int'(busy), 0);

    // R8: duplicate ack, done time unchanged
    run_shoot(0, 'h0c0de, 4'b0110, 0, 3, 4'b0010, 2, 1'b1);
    do_reset();
    chk(!ack_err, "R8 reset clears error", int'(ack_err), 0);

    // R7 R8 R11: initiator acks itself on a local-only request
    run_shoot(2, 'h0beef, 4'b0100, 0, 0, 4'b0100, 1, 1'b1);
    do_reset();

    // R8: stray ack while idle
    @(negedge clk);
    ack = 4'b1000;
    @(negedge clk);
    ack = '0;
    chk(ack_err && !busy, "R8 idle ack flagged", int'(ack_err), 1);
    repeat (3) @(negedge clk);
    chk(ack_err, "R8 error sticky", int'(ack_err), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule